// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Unit

This unit performs an indivisible read-compare-conditional-store on a small internal byte-addressed memory organised as 64-bit words. A caller presents one request: an access width, a byte address, a compare value, swap data, an optional second store word, and the page attributes and permissions that apply to the address. The unit reads the addressed value and widens it to 64 bits with zeros. It compares that value with the full 64-bit compare value. Only on equality does it store the swap data. In every case it returns the old value or a fault code.

The unit also has a paired mode. In this mode, 8 bytes are read and compared at the address with bit 3 cleared. On equality, the swap data and the second store word are written as one 16-byte store to that 16-byte-aligned pair of words. Requests and responses each use a valid/ready handshake. The unit works on one request at a time. A side port lets a testbench preload and inspect memory, and it has effect only while the unit is idle.

Top module: `atomic_cas_unit`

## Requirements
- R1: The size field selects the access width: 0 gives 1 byte, 1 gives 2, 2 gives 4, 3 gives 8. Byte address A lies in word A>>3 at byte lane A[2:0], in little-endian order. The returned old value holds the accessed bytes in its low bytes, and every higher bit is zero.
- R2: The old value is compared with all 64 bits of the compare value. On equality, only the low size bytes of the swap data are stored, starting at the request address. All other memory bytes keep their value.
- R3: On inequality, memory is unchanged and the old value is still returned.
- R4: In paired mode, the size field and address bits 3 and below have no effect on which word is accessed. The 8 bytes at the 16-byte-aligned base (address with bit 3 cleared) are compared. On equality, the swap data goes to the base word and the second store word goes to base+8, both in the same cycle.
- R5: A non-paired address not aligned to its size, or a paired address whose low three bits are not zero, returns fault code 1. No alignment enable bit affects this check.
- R6: A request on a page marked as holding deferred-exception tokens returns fault code 2.
- R7: A request on a page that is not cacheable write-back returns fault code 3.
- R8: If read or write permission is missing, fault code 4 is returned, even when the comparison would fail and no store would happen.
- R9: Faults are ranked in this order: code 1, then 2, then 3, then 4. A faulting request returns zero data and leaves memory unchanged. Code 0 means success.
- R10: Ready is high only when idle. It drops in the cycle after a request is accepted and stays low until the response handshake. While the response waits for ready, its data and code stay stable.
- R11: Side-port writes take effect only while idle. Side-port reads return the addressed word while idle and zero while busy.
- R12: After reset, request ready is high and response valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_size | input | 2 | Access width code |
| req_pair | input | 1 | Paired 8-compare/16-store mode |
| req_addr | input | ADDR_W | Byte address |
| req_swap | input | 64 | Data stored on equality |
| req_cmp | input | 64 | Compare value |
| req_hi | input | 64 | Second store word for paired mode |
| req_nat_page | input | 1 | Page holds deferred-exception tokens |
| req_wb_cache | input | 1 | Page is cacheable write-back |
| req_perm_rd | input | 1 | Read permitted |
| req_perm_wr | input | 1 | Write permitted |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_data | output | 64 | Zero-extended old value, zero on fault |
| rsp_fault | output | 3 | Fault code |
| sb_en | input | 1 | Side port access |
| sb_we | input | 1 | Side port write |
| sb_idx | input | IDX_W | Side port word index |
| sb_wdata | input | 64 | Side port write data |
| sb_rdata | output | 64 | Side port read data |

## Verification
The hardest case to reach is a paired request with address bit 3 set whose store must land on the word below the addressed one while the word above is also overwritten. Equally hard is a permission fault on a request whose comparison would have failed anyway. The stimulus reaches both through a vector table applied to a memory preloaded so that every byte equals its own address. In that table, a hit is forced by taking the compare value from a bench-side byte model. A final side-port sweep of every word then exposes any misplaced or suppressed store.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int WORD_W  = 64;
    localparam int LANES   = WORD_W / 8;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_NATPG = 3'd2,
        FLT_ATTR  = 3'd3,
        FLT_PERM  = 3'd4
    } cas_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } cas_state_e;
endpackage

// File: rtl/cas_fault_check.sv
module cas_fault_check
    import cas_pkg::*;
(
    input  logic       size_valid,
    input  logic [1:0] size,
    input  logic       pair,
    input  logic [2:0] off,
    input  logic       nat_page,
    input  logic       wb_cache,
    input  logic       perm_rd,
    input  logic       perm_wr,
    output cas_fault_e fault
);
    logic [3:0] nbytes;
    logic [2:0] low_mask;
    logic       misaligned;

    always_comb begin
        nbytes     = 4'd1 << size;
        low_mask   = pair ? 3'b111 : 3'(nbytes - 4'd1);
        misaligned = (off & low_mask) != 3'd0;
        fault      = FLT_NONE;
        if (size_valid) begin
            // ranked: alignment, token page, attribute, permission
            if (misaligned)                fault = FLT_ALIGN;
            else if (nat_page)             fault = FLT_NATPG;
            else if (!wb_cache)            fault = FLT_ATTR;
            else if (!(perm_rd && perm_wr)) fault = FLT_PERM;
        end
    end
endmodule

// File: rtl/cas_lane_unit.sv
module cas_lane_unit
    import cas_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [2:0]        off,
    input  logic [1:0]        size,
    input  logic              pair,
    input  logic [WORD_W-1:0] swap,
    output logic [WORD_W-1:0] old_zext,
    output logic [WORD_W-1:0] merged
);
    logic [3:0]        nbytes;
    logic [2:0]        off_e;
    logic [5:0]        shamt;
    logic [3:0]        lane_end;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] swap_sh;

    always_comb begin
        nbytes   = pair ? 4'd8 : (4'd1 << size);
        off_e    = pair ? 3'd0 : off;
        shamt    = {off_e, 3'b000};
        lane_end = {1'b0, off_e} + nbytes;
        shifted  = word_in >> shamt;
        swap_sh  = swap << shamt;
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic keep_old;
        logic take_new;
        assign keep_old = 4'(b) < nbytes;
        assign take_new = (4'(b) >= {1'b0, off_e}) && (4'(b) < lane_end);
        assign old_zext[b*8 +: 8] = keep_old ? shifted[b*8 +: 8] : 8'h00;
        assign merged[b*8 +: 8]   = take_new ? swap_sh[b*8 +: 8] : word_in[b*8 +: 8];
    end
endmodule

// File: rtl/cas_word_mem.sv
module cas_word_mem
    import cas_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [WORD_W-1:0] wd_a,
    input  logic              we_b,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [WORD_W-1:0] wd_b,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [WORD_W-1:0] rd_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [WORD_W-1:0] rd_b
);
    logic [WORD_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) words_q[idx_a] <= wd_a;
        if (we_b) words_q[idx_b] <= wd_b;
    end

    assign rd_a = words_q[ridx_a];
    assign rd_b = words_q[ridx_b];

    // R4: the two halves of a paired store never target one word
    p_pair_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (idx_a != idx_b));
endmodule

// File: rtl/atomic_cas_unit.sv
module atomic_cas_unit
    import cas_pkg::*;
#(
    parameter  int DEPTH  = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic              req_pair,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_swap,
    input  logic [63:0]       req_cmp,
    input  logic [63:0]       req_hi,
    input  logic              req_nat_page,
    input  logic              req_wb_cache,
    input  logic              req_perm_rd,
    input  logic              req_perm_wr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_data,
    output logic [2:0]        rsp_fault,
    input  logic              sb_en,
    input  logic              sb_we,
    input  logic [IDX_W-1:0]  sb_idx,
    input  logic [63:0]       sb_wdata,
    output logic [63:0]       sb_rdata
);
    typedef struct packed {
        cas_state_e        state;
        logic [1:0]        size;
        logic              pair;
        logic [ADDR_W-1:0] addr;
        logic [63:0]       swap;
        logic [63:0]       cmp;
        logic [63:0]       hi;
        logic              nat;
        logic              wb;
        logic              prd;
        logic              pwr;
        logic [63:0]       rdata;
        cas_fault_e        fault;
    } ctx_t;

    ctx_t st_d, st_q;

    logic [IDX_W-1:0] word_idx, base_idx, op_idx;
    logic [63:0]      op_word, old_w, merged_w, side_word;
    cas_fault_e       fault_w;
    logic             in_exec, is_idle, hit_w;
    logic             we_a, we_b;
    logic [IDX_W-1:0] idx_a, idx_b;
    logic [63:0]      wd_a, wd_b;

    assign is_idle  = st_q.state == ST_IDLE;
    assign in_exec  = st_q.state == ST_EXEC;
    assign word_idx = st_q.addr[ADDR_W-1:3];
    assign base_idx = {word_idx[IDX_W-1:1], 1'b0};
    assign op_idx   = st_q.pair ? base_idx : word_idx;

    cas_fault_check u_fault (
        .size_valid (in_exec),
        .size       (st_q.size),
        .pair       (st_q.pair),
        .off        (st_q.addr[2:0]),
        .nat_page   (st_q.nat),
        .wb_cache   (st_q.wb),
        .perm_rd    (st_q.prd),
        .perm_wr    (st_q.pwr),
        .fault      (fault_w)
    );

    cas_lane_unit u_lane (
        .word_in  (op_word),
        .off      (st_q.addr[2:0]),
        .size     (st_q.size),
        .pair     (st_q.pair),
        .swap     (st_q.swap),
        .old_zext (old_w),
        .merged   (merged_w)
    );

    // memory port steering: the exec cycle owns port A/B, idle side port uses A
    always_comb begin
        hit_w = in_exec && (fault_w == FLT_NONE) && (old_w == st_q.cmp);
        we_a  = 1'b0;
        idx_a = op_idx;
        wd_a  = st_q.pair ? st_q.swap : merged_w;
        we_b  = hit_w && st_q.pair;
        idx_b = {base_idx[IDX_W-1:1], 1'b1};
        wd_b  = st_q.hi;
        if (hit_w) begin
            we_a = 1'b1;
        end else if (is_idle && sb_en && sb_we) begin
            we_a  = 1'b1;
            idx_a = sb_idx;
            wd_a  = sb_wdata;
        end
    end

    cas_word_mem #(.DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (we_a),
        .idx_a  (idx_a),
        .wd_a   (wd_a),
        .we_b   (we_b),
        .idx_b  (idx_b),
        .wd_b   (wd_b),
        .ridx_a (op_idx),
        .rd_a   (op_word),
        .ridx_b (sb_idx),
        .rd_b   (side_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.state = ST_EXEC;
                    st_d.size  = req_size;
                    st_d.pair  = req_pair;
                    st_d.addr  = req_addr;
                    st_d.swap  = req_swap;
                    st_d.cmp   = req_cmp;
                    st_d.hi    = req_hi;
                    st_d.nat   = req_nat_page;
                    st_d.wb    = req_wb_cache;
                    st_d.prd   = req_perm_rd;
                    st_d.pwr   = req_perm_wr;
                end
            end
            ST_EXEC: begin
                st_d.state = ST_RESP;
                st_d.fault = fault_w;
                st_d.rdata = (fault_w == FLT_NONE) ? old_w : 64'd0;
            end
            ST_RESP: begin
                if (rsp_ready) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.fault <= FLT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = is_idle;
    assign rsp_valid = st_q.state == ST_RESP;
    assign rsp_data  = st_q.rdata;
    assign rsp_fault = st_q.fault;
    assign sb_rdata  = (is_idle && sb_en) ? side_word : 64'd0;

    // R10: a waiting response keeps its contents
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_fault)));
    // R10: acceptance closes the request side
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9: a fault response carries no data
    p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_data == 64'd0));
    // R9: a faulting request writes nothing
    p_no_store_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && fault_w != FLT_NONE) |-> (!we_a && !we_b));
    // R1: narrow accesses leave the upper result bits zero
    p_zero_extend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !st_q.pair && st_q.size != 2'd3) |-> ((old_w >> (7'd8 << st_q.size)) == 64'd0));
    // R11: the side port never writes during a request
    p_side_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_idle && !in_exec) |-> !we_a);
endmodule

// File: tb/atomic_cas_unit_tb.sv
module atomic_cas_unit_tb_top;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int ADDR_W = IDX_W + 3;
    localparam int NBYTES = DEPTH * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0, req_ready;
    logic [1:0]        req_size = '0;
    logic              req_pair = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_swap = '0, req_cmp = '0, req_hi = '0;
    logic              req_nat_page = 1'b0, req_wb_cache = 1'b1;
    logic              req_perm_rd = 1'b1, req_perm_wr = 1'b1;
    logic              rsp_valid, rsp_ready = 1'b1;
    logic [63:0]       rsp_data;
    logic [2:0]        rsp_fault;
    logic              sb_en = 1'b0, sb_we = 1'b0;
    logic [IDX_W-1:0]  sb_idx = '0;
    logic [63:0]       sb_wdata = '0, sb_rdata;

    atomic_cas_unit #(.DEPTH(DEPTH)) dut_i (.*);

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] mdl [NBYTES];

    typedef struct packed {
        logic [1:0] size;
        logic       pair;
        logic [6:0] addr;
        logic       hit;
        logic       nat;
        logic       wb;
        logic       rd;
        logic       wr;
        logic [2:0] fault;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 7'h03, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd1, 1'b0, 7'h0A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd2, 1'b0, 7'h14, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd3, 1'b0, 7'h18, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd2, 1'b0, 7'h1C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd1, 1'b0, 7'h21, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1},
        '{2'd2, 1'b0, 7'h22, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1},
        '{2'd3, 1'b0, 7'h2C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1},
        '{2'd0, 1'b1, 7'h38, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd3, 1'b1, 7'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd3, 1'b1, 7'h44, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1},
        '{2'd0, 1'b0, 7'h50, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
        '{2'd0, 1'b0, 7'h51, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
        '{2'd0, 1'b0, 7'h52, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4},
        '{2'd0, 1'b0, 7'h53, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4},
        '{2'd1, 1'b0, 7'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1},
        '{2'd3, 1'b0, 7'h58, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd1, 1'b1, 7'h70, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{2'd0, 1'b0, 7'h7F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}
    };

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_word(input int w);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = mdl[w*8 + k];
        return v;
    endfunction

    function automatic logic [63:0] mdl_read(input int base, input int n);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) v[k*8 +: 8] = mdl[base + k];
        return v;
    endfunction

    task automatic side_write(input int w, input logic [63:0] d);
        @(negedge clk);
        sb_en = 1'b1; sb_we = 1'b1; sb_idx = IDX_W'(w); sb_wdata = d;
        @(negedge clk);
        sb_en = 1'b0; sb_we = 1'b0;
    endtask

    task automatic side_read(input int w, output logic [63:0] d);
        @(negedge clk);
        sb_en = 1'b1; sb_we = 1'b0; sb_idx = IDX_W'(w);
        #1 d = sb_rdata;
        sb_en = 1'b0;
    endtask

    // offer one request, return the response sampled at the first negedge it is valid
    task automatic issue(input vec_t v, input logic [63:0] cmp, input logic [63:0] sw,
                         input logic [63:0] hi, output logic [63:0] d, output logic [2:0] f);
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_size = v.size; req_pair = v.pair; req_addr = v.addr;
        req_swap = sw; req_cmp = cmp; req_hi = hi;
        req_nat_page = v.nat; req_wb_cache = v.wb; req_perm_rd = v.rd; req_perm_wr = v.wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 ready after accept", 64'(req_ready), 64'd0);
        while (!rsp_valid && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        d = rsp_data;
        f = rsp_fault;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d, exp_d, rd_w, held_d;
        logic [2:0]  f, held_f;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R12 ready in reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R12 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R12 idle after reset",
              {62'd0, req_ready, rsp_valid}, 64'd2);

        // preload: every byte equals its byte address
        for (int b = 0; b < NBYTES; b++) mdl[b] = 8'(b);
        for (int w = 0; w < DEPTH; w++) side_write(w, mdl_word(w));
        side_read(3, rd_w);
        check(rd_w == mdl_word(3), "R11 side read idle", rd_w, mdl_word(3));

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VT[i];
            automatic int base = v.pair ? (int'(v.addr) & 'h70) : int'(v.addr);
            automatic int n = v.pair ? 8 : (1 << v.size);
            automatic logic [63:0] old = mdl_read(base, n);
            automatic logic [63:0] sw = {8{8'(8'h80 + i)}};
            automatic logic [63:0] hi = {8{8'(8'h40 + i)}};
            automatic logic [63:0] cmp = v.hit ? old : 64'hFFFF_FFFF_FFFF_FFFF;
            automatic string tag;
            case (v.fault)
                3'd1: tag = "R5 unaligned";
                3'd2: tag = "R6 token page";
                3'd3: tag = "R7 attribute";
                3'd4: tag = "R8 permission";
                default: tag = v.pair ? "R4 paired" : (v.hit ? "R2 match" : "R3 mismatch");
            endcase
            issue(v, cmp, sw, hi, d, f);
            exp_d = (v.fault != 3'd0) ? 64'd0 : old;
            check(f == v.fault, {tag, " R9 code"}, 64'(f), 64'(v.fault));
            check(d == exp_d, {tag, " R1 data"}, d, exp_d);
            if (v.fault == 3'd0 && v.hit) begin
                for (int k = 0; k < n; k++) mdl[base + k] = sw[k*8 +: 8];
                if (v.pair) for (int k = 0; k < 8; k++) mdl[base + 8 + k] = hi[k*8 +: 8];
            end
        end

        // memory image after the table: placed, narrow and suppressed stores (R2 R3 R4 R9)
        for (int w = 0; w < DEPTH; w++) begin
            side_read(w, rd_w);
            check(rd_w == mdl_word(w), "R2 R3 R4 R9 memory image", rd_w, mdl_word(w));
        end

        // held response and busy side port (R10 R11)
        rsp_ready = 1'b0;
        begin
            automatic vec_t hv = '{2'd2, 1'b0, 7'h60, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0};
            automatic logic [63:0] old = mdl_read(7'h60, 4);
            issue(hv, old, 64'h0000_0000_1234_5678, 64'd0, held_d, held_f);
            check(held_d == old && held_f == 3'd0, "R2 held response", held_d, old);
            for (int k = 0; k < 4; k++) mdl['h60 + k] = 8'(64'h1234_5678 >> (8*k));
        end
        sb_en = 1'b1; sb_we = 1'b1; sb_idx = IDX_W'(5); sb_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        #1;
        check(sb_rdata == 64'd0, "R11 side read busy", sb_rdata, 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rsp_valid && !req_ready && rsp_data == held_d && rsp_fault == held_f,
                  "R10 hold while stalled", rsp_data, held_d);
        end
        sb_en = 1'b0; sb_we = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 released", 64'(req_ready), 64'd1);
        side_read(5, rd_w);
        check(rd_w == mdl_word(5), "R11 busy write ignored", rd_w, mdl_word(5));
        side_read(12, rd_w);
        check(rd_w == mdl_word(12), "R2 word after held request", rd_w, mdl_word(12));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule